// File: doc/BRIEF.md
# Bidirectional Parallel Port Register Block

This block is the host-side register file of a printer-style parallel port that can also receive bytes. A small byte-wide register bus reaches three adjacent 8-bit registers: data, status and control. The data register feeds an 8-bit pin bus that has a tri-state enable. The control register drives four open-collector lines and holds two mode bits. The status register reports five printer inputs.

Every pin input passes through a two-flop synchronizer before it is read back or used to detect an edge. A direction bit turns the data bus into an input while writes are still stored. The control lines read back the actual pin levels, so an external device that pulls a line low can use it as an input. A rising edge on the acknowledge input raises a one-clock interrupt pulse, but only while the interrupt driver is enabled.

Top module: `pport_regs`

## Requirements
- R1: Register offset 0 is data, offset 1 is status and offset 2 is control. A read of offset 3 returns 0xFF and a write to offset 3 changes nothing.
- R2: After reset `dat_out` is 0x00, `dat_oe` is 1, `ctl_pull_low` is 0000, `irq_oe` is 0 and `irq_pulse` is 0.
- R3: A write to offset 0 appears on `dat_out` at the next clock and stays there until the next data write. A read of offset 0 returns the level of `dat_in` as sampled through the two-flop synchronizer.
- R4: While control bit 5 is 1, `dat_oe` is 0 and data writes are still stored. When bit 5 returns to 0, the last value written is driven.
- R5: A status read returns {~busy, ack_n, nopaper, selected, error_n, 3'b111} from the synchronized `sts_in` bits [4] down to [0].
- R6: Control bits 3..0 give the pin levels reg XOR 1011: bits 3, 1 and 0 are inverted and bit 2 is not. `ctl_pull_low[i]` is 1 exactly when the level of pin i is low. Writing 0100 releases all four lines.
- R7: Control read bits 3..0 return the synchronized `ctl_in` pin levels XOR 1011. This value can differ from the written value when an external device pulls a line low.
- R8: Control read bits 7:6 are 1, and bits 7:6 of a write are ignored. Bits 5 and 4 read back as written.
- R9: `irq_oe` equals control bit 4. While that bit is 1, each rising edge of the acknowledge pin (`sts_in[3]`) gives exactly one `irq_pulse` that lasts one clock.
- R10: A falling edge of acknowledge, or any edge while control bit 4 is 0, gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| dat_out | output | 8 | Data pin drive value |
| dat_oe | output | 1 | Data pin driver enable |
| dat_in | input | 8 | Data pin levels |
| ctl_pull_low | output | 4 | Open-collector pull-down per control line |
| ctl_in | input | 4 | Control pin levels |
| sts_in | input | 5 | busy, ack_n, nopaper, selected, error_n |
| irq_pulse | output | 1 | Interrupt request pulse |
| irq_oe | output | 1 | Interrupt driver enable |

## Verification
Some properties are checked on every cycle. The interrupt pulse lasts one clock and only occurs while the driver is enabled. Data writes show up on the pins at the next clock. The direction and driver enables change only after a control write. Writing the release pattern frees all lines, and the fixed read bits read as ones. Other behaviour needs the bench's scenarios with modelled external pins: readback through the synchronizer, the open-collector override, the storage of writes in input mode, and the counting of edges.

// File: rtl/pport_pkg.sv
// Package: shared offsets, inversion masks and reset constants for the
// parallel port register block. Assumes byte-wide registers.
package pport_pkg;
    localparam int DW = 8;
    localparam int CW = 4;
    localparam int SW = 5;
    localparam logic [1:0] OFS_DATA = 2'd0;
    localparam logic [1:0] OFS_STAT = 2'd1;
    localparam logic [1:0] OFS_CTRL = 2'd2;
    // register-to-pin inversion for control bits 3..0 (1 = inverted)
    localparam logic [CW-1:0] CTL_INV = 4'b1011;
    // register value that releases every control pin high
    localparam logic [CW-1:0] CTL_RELEASE = 4'b0100;
endpackage

// File: rtl/pport_sync.sv
// Module: multi-stage synchronizer for asynchronous pin inputs.
// Assumes each bit is independent; no bus coherency is implied.
module pport_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    // shift the pin value through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= '1;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/pport_regfile.sv
// Module: writable state of the port (data latch, mode bits, control bits).
// Assumes one access per clock; writes take effect at the next edge.
module pport_regfile
    import pport_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    addr,
    input  logic [5:0]    wdata,
    input  logic [DW-1:0] wdata_full,
    output logic [DW-1:0] data_q,
    output logic          in_mode,
    output logic          irq_en,
    output logic [CW-1:0] ctl_q
);
    // latch the data byte on a data-register write
    always_ff @(posedge clk) begin
        if (!rst_n)                          data_q <= '0;
        else if (wr_en && addr == OFS_DATA)  data_q <= wdata_full;
    end

    // latch mode and control bits on a control-register write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_mode <= 1'b0;
            irq_en  <= 1'b0;
            ctl_q   <= CTL_RELEASE;
        end else if (wr_en && addr == OFS_CTRL) begin
            in_mode <= wdata[5];
            irq_en  <= wdata[4];
            ctl_q   <= wdata[CW-1:0];
        end
    end
endmodule

// File: rtl/pport_irq.sv
// Module: rising-edge detector on the synchronized acknowledge line with
// a gated one-clock request pulse. Assumes ack_s is already synchronous.
module pport_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_s,
    input  logic irq_en,
    output logic irq_pulse
);
    logic ack_prev;

    // remember the previous acknowledge level
    always_ff @(posedge clk) begin
        if (!rst_n) ack_prev <= 1'b1;
        else        ack_prev <= ack_s;
    end

    // emit one pulse per low-to-high transition while enabled
    always_ff @(posedge clk) begin
        if (!rst_n) irq_pulse <= 1'b0;
        else        irq_pulse <= irq_en && ack_s && !ack_prev;
    end
endmodule

// File: rtl/pport_regs.sv
// Module: top of the bidirectional parallel port register block.
// Decodes byte accesses, applies pin inversions, and drives the tri-state
// and open-collector enables. Assumes pins are sampled asynchronously.
module pport_regs
    import pport_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_sel,
    input  logic         bus_wr,
    input  logic [1:0]   bus_addr,
    input  logic [7:0]   bus_wdata,
    output logic [7:0]   bus_rdata,
    output logic [7:0]   dat_out,
    output logic         dat_oe,
    input  logic [7:0]   dat_in,
    output logic [3:0]   ctl_pull_low,
    input  logic [3:0]   ctl_in,
    input  logic [4:0]   sts_in,
    output logic         irq_pulse,
    output logic         irq_oe
);
    localparam int PW = DW + CW + SW;

    logic [PW-1:0] pins_s;
    logic [DW-1:0] dat_s;
    logic [CW-1:0] ctl_s;
    logic [SW-1:0] sts_s;
    logic [DW-1:0] data_q;
    logic [CW-1:0] ctl_q;
    logic          in_mode, irq_en;

    pport_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({dat_in, ctl_in, sts_in}), .q(pins_s)
    );
    assign {dat_s, ctl_s, sts_s} = pins_s;

    pport_regfile u_rf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(bus_sel && bus_wr), .addr(bus_addr),
        .wdata(bus_wdata[5:0]), .wdata_full(bus_wdata),
        .data_q(data_q), .in_mode(in_mode), .irq_en(irq_en), .ctl_q(ctl_q)
    );

    pport_irq u_irq (
        .clk(clk), .rst_n(rst_n), .ack_s(sts_s[3]),
        .irq_en(irq_en), .irq_pulse(irq_pulse)
    );

    // pin-side drive: data bus, direction, open-collector pulls, irq driver
    always_comb begin
        dat_out      = data_q;
        dat_oe       = !in_mode;
        ctl_pull_low = ~(ctl_q ^ CTL_INV);
        irq_oe       = irq_en;
    end

    // register read multiplexer
    always_comb begin
        unique case (bus_addr)
            OFS_DATA: bus_rdata = dat_s;
            OFS_STAT: bus_rdata = {~sts_s[4], sts_s[3:0], 3'b111};
            OFS_CTRL: bus_rdata = {2'b11, in_mode, irq_en, ctl_s ^ CTL_INV};
            default:  bus_rdata = 8'hFF;
        endcase
    end
endmodule

// File: rtl/pport_regs_chk.sv
// Checker: temporal properties of the parallel port register block.
module pport_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_sel,
    input logic       bus_wr,
    input logic [1:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic [7:0] dat_out,
    input logic       dat_oe,
    input logic [3:0] ctl_pull_low,
    input logic       irq_pulse,
    input logic       irq_oe
);
    assert_irq_one_clock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);
    assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> irq_oe);
    assert_data_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 2'd0) |=> dat_out == $past(bus_wdata));
    assert_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr && bus_addr == 2'd0) |=> $stable(dat_out));
    assert_dir_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr && bus_addr == 2'd2) |=> ($stable(dat_oe) && $stable(irq_oe)));
    assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 2'd2 && bus_wdata[3:0] == 4'b0100)
        |=> ctl_pull_low == 4'b0000);
    assert_ctrl_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd2) |-> bus_rdata[7:6] == 2'b11);
    assert_stat_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd1) |-> bus_rdata[2:0] == 3'b111);
endmodule

bind pport_regs pport_regs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dat_out(dat_out), .dat_oe(dat_oe), .ctl_pull_low(ctl_pull_low),
    .irq_pulse(irq_pulse), .irq_oe(irq_oe)
);

// File: tb/test_pport_regs.sv
module test_pport_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata, dat_out, dat_in;
    logic       dat_oe, irq_pulse, irq_oe;
    logic [3:0] ctl_pull_low, ctl_in;
    logic [4:0] sts_in = 5'b01111;
    logic [7:0] ext_d = 8'h00;
    logic [3:0] ext_low = 4'b0000;
    int total = 0, bad = 0, irq_cnt = 0;
    logic [7:0] m_data = 8'h00;
    logic [5:0] m_ctl = 6'b000100;

    always #2.5 clk = ~clk;

    // external pin model: bus keeper and open-collector wired-AND
    assign dat_in = dat_oe ? dat_out : ext_d;
    assign ctl_in = ~(ctl_pull_low | ext_low);

    pport_regs i_pport_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dat_out(dat_out), .dat_oe(dat_oe), .dat_in(dat_in),
        .ctl_pull_low(ctl_pull_low), .ctl_in(ctl_in), .sts_in(sts_in),
        .irq_pulse(irq_pulse), .irq_oe(irq_oe)
    );

    always @(negedge clk) if (rst_n && irq_pulse) irq_cnt++;

    function automatic logic [7:0] exp_read(logic [1:0] a);
        logic [3:0] lvl;
        lvl = ~((~(m_ctl[3:0] ^ 4'b1011)) | ext_low);
        case (a)
            2'd0: return m_ctl[5] ? ext_d : m_data;
            2'd1: return {~sts_in[4], sts_in[3:0], 3'b111};
            2'd2: return {2'b11, m_ctl[5:4], lvl ^ 4'b1011};
            default: return 8'hFF;
        endcase
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        if (a == 2'd0) m_data = d;
        if (a == 2'd2) m_ctl = d[5:0];
    endtask

    task automatic rd_check(string req, logic [1:0] a);
        repeat (3) @(negedge clk);
        bus_addr = a; bus_sel = 1'b1;
        #1;
        check(req, bus_rdata, exp_read(a));
        bus_sel = 1'b0;
    endtask

    task automatic ack_edges(int n);
        for (int i = 0; i < n; i++) begin
            repeat (4) @(negedge clk); sts_in[3] = 1'b0;
            repeat (4) @(negedge clk); sts_in[3] = 1'b1;
        end
        repeat (5) @(negedge clk);
    endtask

    initial begin
        #500000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        check("R2 dat_out", dat_out, 8'h00);
        check("R2 oe/irq", {5'b0, dat_oe, irq_oe, irq_pulse}, 8'b100);
        check("R2 pull", {4'b0, ctl_pull_low}, 8'h00);
        // R3 data write and readback
        wr(2'd0, 8'hA5);
        check("R3 dat_out", dat_out, 8'hA5);
        rd_check("R3 data read", 2'd0);
        // R6 control drive: reg 0000 -> levels 1011 -> pull 0100
        wr(2'd2, 8'h00);
        check("R6 pull", {4'b0, ctl_pull_low}, 8'h04);
        wr(2'd2, 8'hC4);
        check("R6 release", {4'b0, ctl_pull_low}, 8'h00);
        // R8 bits 7:6 ignored
        rd_check("R8 ctrl read", 2'd2);
        // R7 external pull overrides released line
        ext_low = 4'b1001;
        rd_check("R7 ctrl readback", 2'd2);
        ext_low = 4'b0000;
        // R5 status mapping
        sts_in = 5'b10110;
        rd_check("R5 status", 2'd1);
        sts_in = 5'b01001;
        rd_check("R5 status", 2'd1);
        // R1 offset 3
        wr(2'd3, 8'h12);
        rd_check("R1 ofs3", 2'd3);
        check("R1 ofs3 no effect", dat_out, 8'hA5);
        // R4 input mode stores writes
        wr(2'd2, 8'h24);
        check("R4 oe low", {7'b0, dat_oe}, 8'h00);
        ext_d = 8'h3C;
        wr(2'd0, 8'h77);
        rd_check("R4 input read", 2'd0);
        wr(2'd2, 8'h04);
        check("R4 stored drive", dat_out, 8'h77);
        rd_check("R4 back to out", 2'd0);
        // R9 / R10 interrupt edges
        sts_in[3] = 1'b1;
        wr(2'd2, 8'h14);
        check("R9 irq_oe", {7'b0, irq_oe}, 8'h01);
        irq_cnt = 0;
        ack_edges(3);
        check("R9 pulse count", irq_cnt[7:0], 8'd3);
        irq_cnt = 0;
        repeat (4) @(negedge clk); sts_in[3] = 1'b0;
        repeat (6) @(negedge clk);
        check("R10 falling edge", irq_cnt[7:0], 8'd0);
        sts_in[3] = 1'b1; repeat (6) @(negedge clk);
        wr(2'd2, 8'h04);
        irq_cnt = 0;
        ack_edges(2);
        check("R10 disabled", irq_cnt[7:0], 8'd0);
        check("R10 irq_oe off", {7'b0, irq_oe}, 8'h00);
        // random mix: R3 R4 R5 R7 R8
        void'($urandom(1234));
        for (int k = 0; k < 200; k++) begin
            int op;
            op = $urandom_range(0, 3);
            ext_d   = 8'($urandom);
            ext_low = 4'($urandom);
            sts_in  = 5'($urandom) | 5'b01000;
            if (op == 0) wr(2'd0, 8'($urandom));
            else if (op == 1) wr(2'd2, 8'($urandom) & 8'hEF);
            rd_check("R3/R4 rand data", 2'd0);
            rd_check("R5 rand status", 2'd1);
            rd_check("R7/R8 rand ctrl", 2'd2);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule